// File: doc/BRIEF.md
# Staged Reset Sequencer with Cause Capture

This block produces the internal resets of a small microcontroller-style system. It merges five reset requests into one sequencer: loss of supply, an active-low board pin, a software request, a watchdog expiry and a brown-out flag. Every request that passes the filters is stored in a sticky cause register that software can read and clear.

Power-up takes two timed stages. The sequencer first waits a programmable number of main-clock cycles for the slow RC oscillator to settle, with the crystal disabled. It then enables the crystal and waits a second programmable count, and also waits for the crystal-ready flag. Only then does it release the CPU and peripheral resets. Release goes through a synchroniser, and a one-cycle `boot_start` pulse marks the start of fetch from the reset vector. A supply drop below the lower threshold or a brown-out asserts reset at once, without waiting for a clock edge. Software, watchdog and pin requests only repeat the crystal stage.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Cause bits are fixed as follows: bit0 power-on, bit1 external pin, bit2 software, bit3 watchdog, bit4 brown-out. An accepted request from a source sets its own bit.
- R2: While `sup_lo` is high, reset is forced. This assertion is asynchronous: `core_rst` and `periph_rst` go high without waiting for an edge. From the next edge on, `xtal_en` is 0, `boot_start` is 0 and `cause` is all zeros.
- R3: Power-up starts with `sup_lo` low and `sup_hi` high. `xtal_en` is low for the first RC_CYC+1 clock edges and goes high on edge RC_CYC+2.
- R4: The core leaves reset only once the crystal stage has lasted at least XTAL_CYC cycles and `xtal_rdy` is high. While `xtal_rdy` is low, reset stays asserted. `core_rst` is never low while `xtal_en` is low.
- R5: Reset release is synchronous. `core_rst` and `periph_rst` fall together, two edges after the sequencer enters its run state. With `xtal_rdy` already high, this is edge RC_CYC+XTAL_CYC+4 after power-up.
- R6: `boot_start` is high for exactly one cycle, on the edge where `core_rst` falls.
- R7: A one-cycle `sw_req` or `wdt_req` in the run state has these effects: reset is asserted on the second edge, `xtal_en` stays high, and reset is released on edge XTAL_CYC+3.
- R8: A software or watchdog request during the RC stage sets its cause bit. It neither ends the RC stage early nor delays it.
- R9: `ext_rst_n` goes through a two-flop synchroniser and a DEB_CYC-cycle debounce. A low pulse of 2 cycles is ignored. A held low asserts reset on edge DEB_CYC+4 and keeps reset asserted while it lasts.
- R10: `bod_flag` asserts reset asynchronously and returns the sequencer to the RC stage, so `xtal_en` drops. After it clears, release follows on edge RC_CYC+XTAL_CYC+2.
- R11: Cause bits are sticky. A 1 in `cause_clr` clears the matching bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R12: A power-on event writes `cause` to 5'b00001, which clears the other bits.
- R13: A low `sup_hi` while `sup_lo` stays low has no effect. This gives hysteresis between the two thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| sup_lo | input | 1 | Supply below lower (falling) threshold |
| sup_hi | input | 1 | Supply above upper (rising) threshold |
| bod_flag | input | 1 | Brown-out indication, level |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| sw_req | input | 1 | Software reset request, one-cycle pulse |
| wdt_req | input | 1 | Watchdog expiry, one-cycle pulse |
| xtal_rdy | input | 1 | Crystal oscillator ready flag |
| cause_clr | input | 5 | Write-one-to-clear mask for `cause` |
| xtal_en | output | 1 | Crystal oscillator enable |
| core_rst | output | 1 | CPU reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| boot_start | output | 1 | One-cycle pulse at reset release |
| cause | output | 5 | Sticky reset-cause bits |

## Verification
Most wrong internal states show up as the wrong edge count. A stage counter that is off by one moves the rise of `xtal_en` or the fall of `core_rst` by one cycle, and the bench measures both exactly after power-up, after a watchdog pulse and after a brown-out. A sequencer that returns to the wrong stage shows within two edges as an unexpected drop of `xtal_en`. A request that is not acted on leaves `core_rst` low on the second edge. A filter or cause-logic fault shows directly on `cause` in the cycle after the event.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_RCW = 2'd1,
    ST_XTW = 2'd2,
    ST_RUN = 2'd3
  } seq_state_t;

  localparam int NSRC  = 5;
  localparam int C_POR = 0;
  localparam int C_EXT = 1;
  localparam int C_SW  = 2;
  localparam int C_WDT = 3;
  localparam int C_BOD = 4;
endpackage

// File: rtl/rsc_ext_filter.sv
module rsc_ext_filter #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic srst,
  input  logic pin_n,
  output logic act,
  output logic act_rise
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic          act_prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      sync_q     <= 2'b11;
      filt_q     <= 1'b1;
      cnt_q      <= '0;
      act_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], pin_n};
      act_prev_q <= ~filt_q;
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act      = ~filt_q;
  assign act_rise = ~filt_q & ~act_prev_q;
endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
  import rsc_pkg::*;
#(
  parameter int RC_CYC   = 3200,
  parameter int XTAL_CYC = 24000
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       sup_hi,
  input  logic       bod,
  input  logic       ext_act,
  input  logic       sw_req,
  input  logic       wdt_req,
  input  logic       xtal_rdy,
  output seq_state_t state_q,
  output logic       pwr_ok,
  output logic       por_ev,
  output logic       hold_rst
);
  localparam int MAXC = (RC_CYC > XTAL_CYC) ? RC_CYC : XTAL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RC_LAST = CW'(RC_CYC - 1);
  localparam logic [CW-1:0] XT_LAST = CW'(XTAL_CYC - 1);

  seq_state_t    state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwr_ok_q;
  logic          xrestart;

  assign xrestart = ext_act | sw_req | wdt_req;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_OFF: begin
        if (pwr_ok_q) begin
          state_d = ST_RCW;
          cnt_d   = '0;
        end
      end
      ST_RCW: begin
        if (bod) begin
          cnt_d = '0;
        end else if (cnt_q == RC_LAST) begin
          state_d = ST_XTW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XTW: begin
        if (bod) begin
          state_d = ST_RCW;
          cnt_d   = '0;
        end else if (xrestart) begin
          cnt_d = '0;
        end else if (cnt_q == XT_LAST) begin
          if (xtal_rdy) state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (bod) begin
          state_d = ST_RCW;
          cnt_d   = '0;
        end else if (xrestart) begin
          state_d = ST_XTW;
          cnt_d   = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      pwr_ok_q <= 1'b0;
      state_q  <= ST_OFF;
      cnt_q    <= '0;
    end else begin
      if (sup_hi) pwr_ok_q <= 1'b1;
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pwr_ok   = pwr_ok_q;
  assign por_ev   = (state_q == ST_OFF) && pwr_ok_q;
  assign hold_rst = (state_d != ST_RUN);
endmodule

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic hold,
  output logic rst_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      q <= '1;
    else if (hold) q <= '1;
    else           q <= {q[STAGES-2:0], 1'b0};
  end

  assign rst_o = q[STAGES-1];
endmodule

// File: rtl/rsc_cause_reg.sv
module rsc_cause_reg
  import rsc_pkg::*;
(
  input  logic            clk,
  input  logic            srst,
  input  logic            por_ev,
  input  logic [NSRC-1:0] set_ev,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] cause
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    if (g == C_POR) begin : g_por
      always_ff @(posedge clk) begin
        if (srst)        cause[g] <= 1'b0;
        else if (por_ev) cause[g] <= 1'b1;
        else             cause[g] <= (cause[g] & ~clr[g]) | set_ev[g];
      end
    end else begin : g_src
      always_ff @(posedge clk) begin
        if (srst || por_ev) cause[g] <= 1'b0;
        else                cause[g] <= (cause[g] & ~clr[g]) | set_ev[g];
      end
    end
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int RC_CYC      = 3200,
  parameter int XTAL_CYC    = 24000,
  parameter int DEB_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            sup_lo,
  input  logic            sup_hi,
  input  logic            bod_flag,
  input  logic            ext_rst_n,
  input  logic            sw_req,
  input  logic            wdt_req,
  input  logic            xtal_rdy,
  input  logic [NSRC-1:0] cause_clr,
  output logic            xtal_en,
  output logic            core_rst,
  output logic            periph_rst,
  output logic            boot_start,
  output logic [NSRC-1:0] cause
);
  seq_state_t      seq_state;
  logic            in_run;
  logic            pwr_ok, por_ev, hold_rst;
  logic            ext_act, ext_rise;
  logic            arst_any, sync_rst;
  logic            core_q, periph_q, boot_q;
  logic [NSRC-1:0] set_ev;

  assign arst_any = sup_lo | bod_flag;

  rsc_ext_filter #(.DEB_CYC(DEB_CYC)) u_ext (
    .clk(clk), .srst(sup_lo), .pin_n(ext_rst_n),
    .act(ext_act), .act_rise(ext_rise)
  );

  rsc_seq_fsm #(.RC_CYC(RC_CYC), .XTAL_CYC(XTAL_CYC)) u_fsm (
    .clk(clk), .srst(sup_lo), .sup_hi(sup_hi), .bod(bod_flag),
    .ext_act(ext_act), .sw_req(sw_req), .wdt_req(wdt_req),
    .xtal_rdy(xtal_rdy), .state_q(seq_state), .pwr_ok(pwr_ok),
    .por_ev(por_ev), .hold_rst(hold_rst)
  );

  rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst(arst_any), .hold(hold_rst), .rst_o(sync_rst)
  );

  always_comb begin
    set_ev        = '0;
    set_ev[C_EXT] = ext_rise & pwr_ok;
    set_ev[C_SW]  = sw_req   & pwr_ok;
    set_ev[C_WDT] = wdt_req  & pwr_ok;
    set_ev[C_BOD] = bod_flag & pwr_ok;
  end

  rsc_cause_reg u_cause (
    .clk(clk), .srst(sup_lo), .por_ev(por_ev),
    .set_ev(set_ev), .clr(cause_clr), .cause(cause)
  );

  always_ff @(posedge clk or posedge arst_any) begin
    if (arst_any) begin
      core_q   <= 1'b1;
      periph_q <= 1'b1;
      boot_q   <= 1'b0;
    end else begin
      core_q   <= sync_rst;
      periph_q <= sync_rst;
      boot_q   <= core_q & ~sync_rst;
    end
  end

  assign in_run     = (seq_state == ST_RUN);
  assign xtal_en    = (seq_state == ST_XTW) || (seq_state == ST_RUN);
  assign core_rst   = core_q;
  assign periph_rst = periph_q;
  assign boot_start = boot_q;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic       clk,
  input logic       sup_lo,
  input logic       bod_flag,
  input logic       sw_req,
  input logic       in_run,
  input logic       xtal_en,
  input logic       core_rst,
  input logic       periph_rst,
  input logic       boot_start,
  input logic [4:0] cause,
  input logic [4:0] cause_clr
);
  p_boot_edge_r6: assert property (@(posedge clk) disable iff (sup_lo)
    boot_start |-> (!core_rst && $past(core_rst)));

  p_boot_single_r6: assert property (@(posedge clk) disable iff (sup_lo)
    boot_start |=> !boot_start);

  p_xtal_first_r4: assert property (@(posedge clk) disable iff (sup_lo)
    !core_rst |-> xtal_en);

  p_bod_async_r10: assert property (@(posedge clk) disable iff (sup_lo)
    bod_flag |-> (core_rst && periph_rst));

  p_sw_restart_r7: assert property (@(posedge clk) disable iff (sup_lo)
    (sw_req && in_run && !bod_flag) |-> ##2 core_rst);

  p_sync_release_r5: assert property (@(posedge clk) disable iff (sup_lo)
    $fell(core_rst) |-> ($past(in_run) && $past(in_run, 2)));

  p_sticky_r11: assert property (@(posedge clk) disable iff (sup_lo)
    (|($past(cause) & ~cause & ~$past(cause_clr))) |-> (cause == 5'b00001));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk(clk), .sup_lo(sup_lo), .bod_flag(bod_flag), .sw_req(sw_req),
  .in_run(in_run), .xtal_en(xtal_en), .core_rst(core_rst),
  .periph_rst(periph_rst), .boot_start(boot_start),
  .cause(cause), .cause_clr(cause_clr)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int RC  = 8;
  localparam int XT  = 12;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic sup_lo, sup_hi, bod_flag, ext_rst_n, sw_req, wdt_req, xtal_rdy;
  logic [4:0] cause_clr;
  logic xtal_en, core_rst, periph_rst, boot_start;
  logic [4:0] cause;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rst_seq_ctrl #(.RC_CYC(RC), .XTAL_CYC(XT), .DEB_CYC(DEB), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .sup_lo(sup_lo), .sup_hi(sup_hi), .bod_flag(bod_flag),
    .ext_rst_n(ext_rst_n), .sw_req(sw_req), .wdt_req(wdt_req),
    .xtal_rdy(xtal_rdy), .cause_clr(cause_clr), .xtal_en(xtal_en),
    .core_rst(core_rst), .periph_rst(periph_rst), .boot_start(boot_start),
    .cause(cause)
  );

  // kind[7:6]: 0 software pulse, 1 watchdog pulse, 2 two-cycle pin glitch
  // [5]: reset expected on the second edge, [4:0]: expected cause
  localparam logic [7:0] VEC [3] = '{
    {2'd0, 1'b1, 5'b00100},
    {2'd1, 1'b1, 5'b01000},
    {2'd2, 1'b0, 5'b00000}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    cause_clr = 5'b11111;
    tick(1);
    cause_clr = 5'b00000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sup_lo = 1'b1; sup_hi = 1'b0; bod_flag = 1'b0; ext_rst_n = 1'b1;
    sw_req = 1'b0; wdt_req = 1'b0; xtal_rdy = 1'b0; cause_clr = '0;
    tick(5);
    chk("R2 rst", {core_rst, periph_rst, xtal_en, boot_start}, 4'b1100);
    chk("R2 cause", cause, 5'b00000);

    // power-up, crystal not ready
    sup_lo = 1'b0; sup_hi = 1'b1;
    tick(RC + 1);
    chk("R3 xtal off", xtal_en, 1'b0);
    tick(1);
    chk("R3 xtal on", xtal_en, 1'b1);
    tick(XT + 10);
    chk("R4 wait rdy", core_rst, 1'b1);
    xtal_rdy = 1'b1;
    tick(2);
    chk("R5 still held", core_rst, 1'b1);
    tick(1);
    chk("R5 release", {core_rst, periph_rst}, 2'b00);
    chk("R6 boot", boot_start, 1'b1);
    tick(1);
    chk("R6 boot end", boot_start, 1'b0);
    chk("R12 por cause", cause, 5'b00001);
    clear_all();

    // vector table: requests from the run state
    for (int i = 0; i < 3; i++) begin
      logic [1:0] kind;
      kind = VEC[i][7:6];
      if (kind == 2'd0) sw_req = 1'b1;
      if (kind == 2'd1) wdt_req = 1'b1;
      if (kind == 2'd2) ext_rst_n = 1'b0;
      tick(1);
      sw_req = 1'b0; wdt_req = 1'b0;
      tick(1);
      ext_rst_n = 1'b1;
      chk("R7/R9 assert", core_rst, VEC[i][5]);
      tick(XT + 4);
      chk("R7/R9 released", core_rst, 1'b0);
      chk("R1 cause", cause, VEC[i][4:0]);
      clear_all();
      chk("R11 clear", cause, 5'b00000);
    end

    // watchdog exact timing
    wdt_req = 1'b1;
    tick(1);
    wdt_req = 1'b0;
    chk("R7 xtal kept", xtal_en, 1'b1);
    tick(XT + 1);
    chk("R7 held", core_rst, 1'b1);
    tick(1);
    chk("R7 release", {core_rst, boot_start}, 2'b01);
    tick(2);

    // set wins over clear; clear of another bit
    sw_req = 1'b1; cause_clr = 5'b01100;
    tick(1);
    sw_req = 1'b0; cause_clr = 5'b00000;
    chk("R11 set wins", cause, 5'b00100);
    tick(XT + 4);
    cause_clr = 5'b00100;
    tick(1);
    cause_clr = 5'b00000;
    chk("R11 w1c", cause, 5'b00000);

    // held pin
    ext_rst_n = 1'b0;
    tick(DEB + 3);
    chk("R9 not yet", core_rst, 1'b0);
    tick(1);
    chk("R9 asserted", core_rst, 1'b1);
    tick(20);
    chk("R9 held", core_rst, 1'b1);
    chk("R1 ext cause", cause, 5'b00010);
    ext_rst_n = 1'b1;
    tick(XT + DEB + 10);
    chk("R9 release", core_rst, 1'b0);
    clear_all();

    // brown-out with software pulse during RC stage
    bod_flag = 1'b1;
    #1;
    chk("R10 async", {core_rst, periph_rst}, 2'b11);
    tick(1);
    chk("R10 xtal off", xtal_en, 1'b0);
    tick(3);
    bod_flag = 1'b0;
    tick(2);
    sw_req = 1'b1;
    tick(1);
    sw_req = 1'b0;
    tick(RC - 4);
    chk("R8 rc not short", xtal_en, 1'b0);
    tick(1);
    chk("R8 rc on time", xtal_en, 1'b1);
    tick(XT + 1);
    chk("R10 held", core_rst, 1'b1);
    tick(1);
    chk("R10 release", core_rst, 1'b0);
    chk("R8 cause", cause, 5'b10100);

    // hysteresis
    sup_hi = 1'b0;
    tick(10);
    chk("R13 no effect", {core_rst, xtal_en}, 2'b01);

    // supply drop and full restart
    sup_lo = 1'b1;
    #1;
    chk("R2 async", core_rst, 1'b1);
    tick(1);
    chk("R2 off", {xtal_en, cause}, 6'b000000);
    tick(3);
    sup_lo = 1'b0; sup_hi = 1'b1;
    tick(3 + RC + XT);
    chk("R5 full held", core_rst, 1'b1);
    tick(1);
    chk("R5 full release", {core_rst, boot_start}, 2'b01);
    chk("R12 por only", cause, 5'b00001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule